// File: doc/BRIEF.md
# Segmented Running-Sum Grant Allocator

This block decides which output requests of a combined input/output-queued cell switch are granted in one contention round. It receives one vector of 2N entries that are already sorted by destination. Each entry is either a queue-status record, which carries the number of cells already held in one output queue, or a request record from an input port. All entries aimed at the same output form one group. In each group the status record comes first and is followed by the requests.

Inside each group the block forms a running count that starts at the status record's occupancy and goes up by one for every further request. A request whose count reaches the speed-up K is refused. So an output receives at most K new cells per round, and fewer if its queue is already partly full. The count is a segmented prefix sum over log2(2N) stages with doubling distance, and a register follows every stage. Each entry's tag and type flag travel with it. The activity bit and destination are dropped at the output. The entry's last field is replaced by the computed count and a deny bit.

Top module: `seg_rank_alloc`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `out_valid` is 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, log2(2N)+1 clock cycles later, carrying the results of that input vector. No other cycle has `out_valid` high.
- R3: A group starts at position i when i is 0, when entry i-1 is idle (activity 0), or when the destination of entry i differs from that of entry i-1. A count never crosses a group start.
- R4: Each entry adds a value to the count. An active status record (type flag 0) adds its field. An active request (type flag 1) adds 1 when entry i-1 is an active request in the same group, and 0 otherwise. The rank of an entry is the sum of these values from the group start up to and including the entry.
- R5: `out_deny` is 1 exactly for an active request whose rank is K or more. It is 0 for granted requests, status records and idle entries.
- R6: Ranks and status contributions saturate at K. Counts are log2(K)+1 bits wide, so a status field above K counts as K.
- R7: `out_tag` and `out_req` of each position equal the input tag and type flag of the same position.
- R8: At position 0 the rank equals that entry's own contribution: the field of an active status record, otherwise 0.
- R9: An idle entry contributes 0 and is never denied. The entry that follows it starts a new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present this cycle |
| in_act | input | 2N | Activity bit per entry |
| in_dest | input | 2N*log2(N) | Destination per entry, entry i in bits [i*log2(N) +: log2(N)] |
| in_req | input | 2N | Type flag per entry: 1 request, 0 queue status |
| in_fld | input | 2N*(log2(K)+1) | Occupancy field of status records (ignored for requests) |
| in_tag | input | 2N*TAG_W | Pass-through tag per entry |
| out_valid | output | 1 | Result vector present |
| out_req | output | 2N | Type flag carried through |
| out_tag | output | 2N*TAG_W | Tag carried through |
| out_rank | output | 2N*(log2(K)+1) | Saturated running count per entry |
| out_deny | output | 2N | 1 = request refused |

## Verification
The bench aims at group edges. These are an address change between two requests with no status record in front, an idle entry inside a run with the same address, and a request at position 0. A design that ignored the activity bit would merge counts across the idle entry and deny requests it should grant. A design that treated every request-after-request pair as +1 without checking the group start would give the first request of a new address a rank of 1. Status fields of K and above check saturation, since a count that wraps past the top of its width would grant requests to a full queue. Vectors sent in consecutive cycles check that results stay in order through the pipeline, and vectors split by gaps check that no result appears where none is due.

// File: rtl/seg_alloc_pkg.sv
package seg_alloc_pkg;
    parameter int N_PORTS = 8;
    parameter int SPEEDUP = 2;
    parameter int TAG_W   = 4;

    localparam int ENT    = 2 * N_PORTS;
    localparam int ADDR_W = $clog2(N_PORTS);
    localparam int SUM_W  = $clog2(SPEEDUP) + 1;
    localparam int NSTG   = $clog2(ENT);
    localparam int LAT    = NSTG + 1;

    typedef logic [SUM_W-1:0] cnt_t;

    typedef struct packed {
        logic              act;
        logic [ADDR_W-1:0] dest;
        logic              req;
        cnt_t              fld;
        logic [TAG_W-1:0]  tag;
    } entry_t;

    typedef struct packed {
        logic             brk;
        logic             act;
        logic             req;
        cnt_t             sum;
        logic [TAG_W-1:0] tag;
    } scan_t;

    function automatic cnt_t sat_add(cnt_t a, cnt_t b);
        logic [SUM_W:0] t;
        t = {1'b0, a} + {1'b0, b};
        if (int'(t) > SPEEDUP) return cnt_t'(SPEEDUP);
        return t[SUM_W-1:0];
    endfunction
endpackage

// File: rtl/seg_seed.sv
module seg_seed
    import seg_alloc_pkg::*;
(
    input  entry_t [ENT-1:0] ent_i,
    output scan_t  [ENT-1:0] seed_o
);
    generate
        for (genvar i = 0; i < ENT; i++) begin : g_pos
            logic brk;
            cnt_t add;
            if (i == 0) begin : g_first
                assign brk = 1'b1;
                assign add = (ent_i[0].act && !ent_i[0].req) ? sat_add(ent_i[0].fld, '0) : '0;
            end else begin : g_rest
                assign brk = !ent_i[i-1].act || (ent_i[i].dest != ent_i[i-1].dest);
                always_comb begin
                    if (!ent_i[i].act)
                        add = '0;
                    else if (!ent_i[i].req)
                        add = sat_add(ent_i[i].fld, '0);
                    else if (!brk && ent_i[i-1].req)
                        add = cnt_t'(1);
                    else
                        add = '0;
                end
            end
            assign seed_o[i] = '{brk: brk, act: ent_i[i].act, req: ent_i[i].req,
                                 sum: add, tag: ent_i[i].tag};
        end
    endgenerate
endmodule

// File: rtl/seg_scan_stage.sv
module seg_scan_stage
    import seg_alloc_pkg::*;
#(
    parameter int DIST = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            v_i,
    input  scan_t [ENT-1:0] d_i,
    output logic            v_o,
    output scan_t [ENT-1:0] q_o
);
    scan_t [ENT-1:0] nxt;

    generate
        for (genvar i = 0; i < ENT; i++) begin : g_pos
            if (i < DIST) begin : g_pass
                assign nxt[i] = d_i[i];
            end else begin : g_comb
                always_comb begin
                    nxt[i] = d_i[i];
                    if (!d_i[i].brk) begin
                        nxt[i].sum = sat_add(d_i[i].sum, d_i[i-DIST].sum);
                        nxt[i].brk = d_i[i-DIST].brk;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            v_o <= 1'b0;
            q_o <= '0;
        end else begin
            v_o <= v_i;
            q_o <= nxt;
        end
    end

    AST_STAGE_VALID_ON: assert property (@(posedge clk) disable iff (rst) v_i |=> v_o); // R2
    AST_STAGE_VALID_OFF: assert property (@(posedge clk) disable iff (rst) !v_i |=> !v_o); // R2
    AST_POS0_KEPT: assert property (@(posedge clk) disable iff (rst) v_i |=> q_o[0] == $past(d_i[0])); // R8
endmodule

// File: rtl/seg_rank_alloc.sv
module seg_rank_alloc
    import seg_alloc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [ENT-1:0]          in_act,
    input  logic [ENT*ADDR_W-1:0]   in_dest,
    input  logic [ENT-1:0]          in_req,
    input  logic [ENT*SUM_W-1:0]    in_fld,
    input  logic [ENT*TAG_W-1:0]    in_tag,
    output logic                    out_valid,
    output logic [ENT-1:0]          out_req,
    output logic [ENT*TAG_W-1:0]    out_tag,
    output logic [ENT*SUM_W-1:0]    out_rank,
    output logic [ENT-1:0]          out_deny
);
    entry_t [ENT-1:0] ent;
    scan_t  [ENT-1:0] seed;
    scan_t  [ENT-1:0] pipe [NSTG+1];
    logic             vld  [NSTG+1];

    always_comb begin
        for (int i = 0; i < ENT; i++) begin
            ent[i].act  = in_act[i];
            ent[i].dest = in_dest[i*ADDR_W +: ADDR_W];
            ent[i].req  = in_req[i];
            ent[i].fld  = in_fld[i*SUM_W +: SUM_W];
            ent[i].tag  = in_tag[i*TAG_W +: TAG_W];
        end
    end

    seg_seed u_seed (.ent_i(ent), .seed_o(seed));

    always_ff @(posedge clk) begin
        if (rst) begin
            vld[0]  <= 1'b0;
            pipe[0] <= '0;
        end else begin
            vld[0]  <= in_valid;
            pipe[0] <= seed;
        end
    end

    generate
        for (genvar s = 0; s < NSTG; s++) begin : g_stage
            seg_scan_stage #(.DIST(1 << s)) u_stage (
                .clk(clk), .rst(rst),
                .v_i(vld[s]), .d_i(pipe[s]),
                .v_o(vld[s+1]), .q_o(pipe[s+1])
            );
        end
    endgenerate

    assign out_valid = vld[NSTG];

    always_comb begin
        for (int i = 0; i < ENT; i++) begin
            out_req[i]                  = pipe[NSTG][i].req;
            out_tag[i*TAG_W +: TAG_W]   = pipe[NSTG][i].tag;
            out_rank[i*SUM_W +: SUM_W]  = pipe[NSTG][i].sum;
            out_deny[i] = pipe[NSTG][i].act && pipe[NSTG][i].req &&
                          (int'(pipe[NSTG][i].sum) >= SPEEDUP);
        end
    end

    generate
        for (genvar i = 0; i < ENT; i++) begin : g_chk
            AST_RANK_CAP: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> int'(pipe[NSTG][i].sum) <= SPEEDUP); // R6
            AST_DENY_ONLY_REQ: assert property (@(posedge clk) disable iff (rst)
                (out_valid && out_deny[i]) |-> out_req[i]); // R5
            AST_SEED_REQ_STEP: assert property (@(posedge clk) disable iff (rst)
                (vld[0] && pipe[0][i].req) |-> int'(pipe[0][i].sum) <= 1); // R4
            AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
                (vld[0] && !pipe[0][i].act) |-> pipe[0][i].sum == '0); // R9
        end
    endgenerate
endmodule

// File: tb/tb_seg_rank_alloc.sv
module tb_seg_rank_alloc;
    import seg_alloc_pkg::*;

    localparam int OW = ENT * (SUM_W + 2 + TAG_W);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [ENT-1:0]        in_act = '0;
    logic [ENT*ADDR_W-1:0] in_dest = '0;
    logic [ENT-1:0]        in_req = '0;
    logic [ENT*SUM_W-1:0]  in_fld = '0;
    logic [ENT*TAG_W-1:0]  in_tag = '0;
    logic                  out_valid;
    logic [ENT-1:0]        out_req;
    logic [ENT*TAG_W-1:0]  out_tag;
    logic [ENT*SUM_W-1:0]  out_rank;
    logic [ENT-1:0]        out_deny;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int a_act [ENT];
    int a_dest[ENT];
    int a_req [ENT];
    int a_fld [ENT];

    logic [OW-1:0] expq[$];
    string         lblq[$];
    logic [LAT-1:0] vhist = '0;

    always #5 clk = ~clk;

    seg_rank_alloc dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_act(in_act), .in_dest(in_dest), .in_req(in_req),
        .in_fld(in_fld), .in_tag(in_tag),
        .out_valid(out_valid), .out_req(out_req), .out_tag(out_tag),
        .out_rank(out_rank), .out_deny(out_deny)
    );

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] reference();
        logic [OW-1:0] r;
        int sum;
        r = '0;
        sum = 0;
        for (int i = 0; i < ENT; i++) begin
            bit start;
            int add;
            logic [TAG_W-1:0] tg;
            tg = in_tag[i*TAG_W +: TAG_W];
            start = (i == 0) || (a_act[i-1] == 0) || (a_dest[i] != a_dest[i-1]);
            if (a_act[i] == 0) add = 0;
            else if (a_req[i] == 0) add = (a_fld[i] > SPEEDUP) ? SPEEDUP : a_fld[i];
            else if (!start && a_req[i-1] == 1) add = 1;
            else add = 0;
            sum = start ? add : sum + add;
            if (sum > SPEEDUP) sum = SPEEDUP;
            r[i*(SUM_W+2+TAG_W) +: (SUM_W+2+TAG_W)] =
                {cnt_t'(sum), (a_act[i] == 1 && a_req[i] == 1 && sum >= SPEEDUP),
                 a_req[i][0], tg};
        end
        return r;
    endfunction

    task automatic send(string lbl);
        for (int i = 0; i < ENT; i++) begin
            in_act[i] = a_act[i][0];
            in_dest[i*ADDR_W +: ADDR_W] = a_dest[i][ADDR_W-1:0];
            in_req[i] = a_req[i][0];
            in_fld[i*SUM_W +: SUM_W] = a_fld[i][SUM_W-1:0];
            in_tag[i*TAG_W +: TAG_W] = TAG_W'($urandom);
        end
        in_valid = 1'b1;
        expq.push_back(reference());
        lblq.push_back(lbl);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic clear_vec();
        for (int i = 0; i < ENT; i++) begin
            a_act[i] = 0; a_dest[i] = 0; a_req[i] = 0; a_fld[i] = 0;
        end
    endtask

    task automatic put(int i, int act, int dest, int req, int fld);
        a_act[i] = act; a_dest[i] = dest; a_req[i] = req; a_fld[i] = fld;
    endtask

    task automatic sorted_vec();
        int p;
        int reqs;
        clear_vec();
        p = 0;
        reqs = 0;
        for (int a = 0; a < N_PORTS; a++) begin
            int nr;
            put(p, 1, a, 0, $urandom_range(0, (1 << SUM_W) - 1));
            p++;
            nr = $urandom_range(0, 3);
            for (int k = 0; k < nr; k++) begin
                if (reqs < N_PORTS && p < ENT) begin
                    put(p, ($urandom_range(0, 9) != 0) ? 1 : 0, a, 1, $urandom_range(0, 3));
                    p++;
                    reqs++;
                end
            end
        end
        while (p < ENT) begin
            put(p, 0, $urandom_range(0, N_PORTS - 1), $urandom_range(0, 1), 0);
            p++;
        end
    endtask

    task automatic raw_vec();
        for (int i = 0; i < ENT; i++)
            put(i, $urandom_range(0, 1), $urandom_range(0, 2), $urandom_range(0, 1),
                $urandom_range(0, (1 << SUM_W) - 1));
    endtask

    // Compare on every falling edge against the queue of expected vectors
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(out_valid == vhist[LAT-1], "R2", "out_valid", out_valid, vhist[LAT-1]);
            if (out_valid && expq.size() > 0) begin
                logic [OW-1:0] e;
                string l;
                e = expq.pop_front();
                l = lblq.pop_front();
                for (int i = 0; i < ENT; i++) begin
                    logic [SUM_W+2+TAG_W-1:0] f;
                    f = e[i*(SUM_W+2+TAG_W) +: (SUM_W+2+TAG_W)];
                    check(out_rank[i*SUM_W +: SUM_W] == f[SUM_W+2+TAG_W-1 -: SUM_W],
                          {l, " R4"}, $sformatf("rank[%0d]", i),
                          out_rank[i*SUM_W +: SUM_W], f[SUM_W+2+TAG_W-1 -: SUM_W]);
                    check(out_deny[i] == f[TAG_W+1], {l, " R5"}, $sformatf("deny[%0d]", i),
                          out_deny[i], f[TAG_W+1]);
                    check(out_req[i] == f[TAG_W] && out_tag[i*TAG_W +: TAG_W] == f[TAG_W-1:0],
                          {l, " R7"}, $sformatf("req/tag[%0d]", i),
                          {out_req[i], out_tag[i*TAG_W +: TAG_W]}, f[TAG_W:0]);
                end
            end
            vhist = {vhist[LAT-2:0], in_valid};
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst = 1'b0;
        @(negedge clk);

        // R8, R4: status at position 0 seeds the count
        clear_vec();
        put(0, 1, 0, 0, 1); put(1, 1, 0, 1, 0); put(2, 1, 0, 1, 0); put(3, 1, 0, 1, 0);
        send("R8");
        // R6: oversized occupancy saturates, every request refused
        clear_vec();
        put(0, 1, 2, 0, (1 << SUM_W) - 1); put(1, 1, 2, 1, 0); put(2, 1, 2, 1, 0);
        send("R6");
        // R3, R9: idle entry and address change start new groups
        clear_vec();
        put(0, 1, 1, 0, 0); put(1, 1, 1, 1, 0); put(2, 1, 1, 1, 0); put(3, 0, 1, 1, 0);
        put(4, 1, 1, 1, 0); put(5, 1, 1, 1, 0); put(6, 1, 1, 1, 0);
        put(7, 1, 2, 1, 0); put(8, 1, 2, 1, 0); put(9, 1, 2, 1, 0);
        send("R3");
        // R9: idle request inside a group is neither counted nor refused
        clear_vec();
        put(0, 1, 3, 0, 1); put(1, 0, 3, 1, 0); put(2, 1, 3, 1, 0); put(3, 1, 3, 1, 0);
        send("R9");
        // R8: request at position 0
        clear_vec();
        put(0, 1, 4, 1, 3); put(1, 1, 4, 1, 0); put(2, 1, 4, 1, 0);
        send("R8");
        repeat (LAT + 2) @(negedge clk);

        for (int n = 0; n < 300; n++) begin
            sorted_vec();
            send("R4");
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end
        for (int n = 0; n < 100; n++) begin
            raw_vec();
            send("R3");
        end
        repeat (LAT + 3) @(negedge clk);
        check(expq.size() == 0, "R2", "pending results", expq.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule